// File: doc/BRIEF.md
# Page-Splitting Flash Program Engine

This block takes one program request (a start address and a byte count) together with a stream of write bytes. It drives a serial flash over a four-wire SPI link in mode 0. The request is cut into program frames so that no frame crosses a 256-byte page boundary. The first piece runs from the start address to the end of its page. Each later piece is either a whole page or whatever is left.

Every piece goes through the same sequence. The engine first polls the device status in separate frames until the busy bit reads clear. It then sends a write enable in its own frame. Last, it sends the program frame: opcode, three address bytes, then the data. Chip select rises straight after the last data byte so the device can begin its internal program cycle.

When the request ends, the engine reports how many data bytes it sent, along with an out-of-range flag and a poll-timeout flag.

Top module: `flash_pgm_engine`

## Requirements
- R1: During and after reset, `req_ready` is 1, `spi_cs_n` is 1, `spi_sck` is 0, `done` is 0, `sent_count` is 0 and both error flags are 0.
- R2: A request with length 0 is accepted and `done` pulses in the cycle after acceptance. `sent_count` is 0, and `spi_cs_n` never falls.
- R3: If `req_addr + req_len > DEV_SIZE` and the length is not zero, the request completes with `err_range` = 1 and `sent_count` = 0, with no bus activity. A request that ends exactly at `DEV_SIZE` is carried out normally.
- R4: If the start offset in its page (address bits 7:0) plus the length is at most 256, the whole write goes out in one program frame.
- R5: Otherwise the first piece has 256 minus the offset bytes. Each later piece has the smaller of 256 and the bytes still to send. Each piece's address is the start address plus the bytes already sent.
- R6: A program frame holds opcode 0x02, then the piece address as 24 bits, high byte first, then the piece's data bytes in stream order. Chip select rises after the last data byte.
- R7: Before each program frame, the engine runs status frames (opcode 0x05 followed by one read byte, in which bit 0 = 1 means busy). It repeats them until bit 0 reads 0, and ignores every other status bit. It then sends a one-byte frame with opcode 0x06. Each of these is a separate chip-select frame.
- R8: If `POLL_MAX` consecutive status reads for one piece all report busy, the request ends with `err_timeout` = 1. `sent_count` holds the bytes sent so far, and no further frame follows.
- R9: `sent_count` is the total of data bytes sent in all program frames. Opcode and address bytes are not counted.
- R10: `wr_ready` is high only inside the data part of a program frame. One byte is consumed per `wr_valid`/`wr_ready` handshake. Gaps in `wr_valid` only delay the frame.
- R11: `spi_sck` idles low and toggles only while `spi_cs_n` is low. `spi_mosi` holds steady while `spi_sck` is high. Bytes go out most significant bit first, and `spi_miso` is sampled on the rising edge.
- R12: `done` is a one-cycle pulse. `req_ready` is high in the following cycle and stays low from acceptance until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Program request offered |
| req_ready | output | 1 | Engine idle, request taken this cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Number of bytes to program |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| err_range | output | 1 | Last request rejected for range |
| err_timeout | output | 1 | Last request aborted on poll timeout |
| sent_count | output | LEN_W | Data bytes sent for the last request |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench aims at page arithmetic that is off by one: a start on the last byte of a page, a write that exactly fills a page, and a write that ends exactly at the device limit. A wrong split would show up as a frame that crosses into the next page, or as an address that skips or repeats bytes. The bench also runs device busy phases of several polls, and busy phases long enough to force a timeout both before the first piece and between pieces. A poll counter that is not cleared per piece, or an abort that still sends a write enable, would produce extra frames or a wrong byte count. Stalled write data checks that `wr_ready` never opens outside a program frame. Range-rejected and empty requests check that nothing moves on the bus.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;

    localparam logic [7:0] CMD_PROGRAM  = 8'h02;
    localparam logic [7:0] CMD_STATUS   = 8'h05;
    localparam logic [7:0] CMD_WR_EN    = 8'h06;
    localparam logic [7:0] STAT_BUSY    = 8'h01;
    localparam logic [7:0] FILL_BYTE    = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_OP,
        ST_POLL_RD,
        ST_WEN,
        ST_PP_OP,
        ST_PP_ADDR,
        ST_PP_DATA,
        ST_GAP,
        ST_FIN
    } eng_state_e;

endpackage

// File: rtl/pgm_chunk_calc.sv
module pgm_chunk_calc #(
    parameter int LEN_W  = 16,
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] off_i,
    input  logic [LEN_W-1:0]  rem_i,
    output logic [LEN_W-1:0]  chunk_o
);
    localparam int PAGE = 1 << PAGE_W;

    logic [PAGE_W:0]  room;
    logic [LEN_W-1:0] room_w;

    // bytes left before the page ends, from the current offset
    assign room    = (PAGE_W+1)'(PAGE) - {1'b0, off_i};
    assign room_w  = LEN_W'(room);
    assign chunk_o = (rem_i < room_w) ? rem_i : room_w;

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rx_o,
    output logic       sck_o,
    output logic       mosi_o
);
    localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic             done;
        logic [DIV_W-1:0] div;
        logic [2:0]       bits;
        logic [7:0]       sh;
        logic [7:0]       rx;
    } shf_regs_t;

    shf_regs_t q, n;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                n.busy = 1'b1;
                n.sh   = tx_i;
                n.div  = '0;
                n.bits = '0;
                n.sck  = 1'b0;
            end
        end else if (q.div == DIV_W'(HALF_CYC - 1)) begin
            n.div = '0;
            if (!q.sck) begin
                n.sck = 1'b1;
                n.rx  = {q.rx[6:0], miso_i};
            end else begin
                n.sck  = 1'b0;
                n.sh   = {q.sh[6:0], 1'b0};
                n.bits = q.bits + 3'd1;
                if (q.bits == 3'd7) begin
                    n.busy = 1'b0;
                    n.done = 1'b1;
                end
            end
        end else begin
            n.div = q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy_o = q.busy;
    assign done_o = q.done;
    assign rx_o   = q.rx;
    assign sck_o  = q.sck;
    assign mosi_o = q.sh[7];

    // R11
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sck |-> q.busy);

    // R11
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sck |-> $stable(mosi_o));

endmodule

// File: rtl/flash_pgm_engine.sv
module flash_pgm_engine
    import flash_pgm_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int LEN_W    = 16,
    parameter int PAGE_W   = 8,
    parameter int DEV_SIZE = 1 << 20,
    parameter int HALF_CYC = 2,
    parameter int POLL_MAX = 1024,
    parameter int GAP_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              done,
    output logic              err_range,
    output logic              err_timeout,
    output logic [LEN_W-1:0]  sent_count,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int PAGE   = 1 << PAGE_W;
    localparam int SUM_W  = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;
    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam int GAP_W  = $clog2(GAP_CYC + 1);
    localparam logic [SUM_W-1:0] DEV_LIM = SUM_W'(DEV_SIZE);

    typedef struct packed {
        eng_state_e        state;
        eng_state_e        nxt;
        logic              issued;
        logic              cs_n;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  chunk_left;
        logic [1:0]        abyte;
        logic [POLL_W-1:0] polls;
        logic [GAP_W-1:0]  gap;
        logic              err_rng;
        logic              err_to;
    } eng_regs_t;

    eng_regs_t q, n;

    logic             sh_start, sh_busy, sh_done;
    logic [7:0]       sh_tx, sh_rx;
    logic [LEN_W-1:0] chunk_len;
    logic [23:0]      addr24;
    logic [SUM_W-1:0] end_sum;
    logic             over, dev_busy;

    pgm_chunk_calc #(.LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_calc (
        .off_i   (q.addr[PAGE_W-1:0]),
        .rem_i   (q.rem),
        .chunk_o (chunk_len)
    );

    spi_byte_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .tx_i    (sh_tx),
        .miso_i  (spi_miso),
        .busy_o  (sh_busy),
        .done_o  (sh_done),
        .rx_o    (sh_rx),
        .sck_o   (spi_sck),
        .mosi_o  (spi_mosi)
    );

    assign addr24   = 24'(q.addr);
    assign end_sum  = SUM_W'(req_addr) + SUM_W'(req_len);
    assign over     = end_sum > DEV_LIM;
    assign dev_busy = |(sh_rx & STAT_BUSY);

    always_comb begin
        n        = q;
        sh_start = 1'b0;
        sh_tx    = FILL_BYTE;
        wr_ready = 1'b0;

        // generic one-byte launch for command states
        if (q.state inside {ST_POLL_OP, ST_POLL_RD, ST_WEN, ST_PP_OP, ST_PP_ADDR}) begin
            if (!q.issued && !sh_busy) begin
                sh_start = 1'b1;
                n.issued = 1'b1;
            end
            if (sh_done) n.issued = 1'b0;
        end

        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    n.addr    = req_addr;
                    n.rem     = req_len;
                    n.len     = req_len;
                    n.cnt     = '0;
                    n.polls   = '0;
                    n.err_rng = 1'b0;
                    n.err_to  = 1'b0;
                    if (req_len == '0) begin
                        n.state = ST_FIN;
                    end else if (over) begin
                        n.err_rng = 1'b1;
                        n.state   = ST_FIN;
                    end else begin
                        n.state = ST_POLL_OP;
                        n.cs_n  = 1'b0;
                    end
                end
            end
            ST_POLL_OP: begin
                sh_tx = CMD_STATUS;
                if (sh_done) n.state = ST_POLL_RD;
            end
            ST_POLL_RD: begin
                sh_tx = FILL_BYTE;
                if (sh_done) begin
                    n.cs_n  = 1'b1;
                    n.state = ST_GAP;
                    n.gap   = '0;
                    if (!dev_busy) begin
                        n.nxt   = ST_WEN;
                        n.polls = '0;
                    end else if (q.polls == POLL_W'(POLL_MAX - 1)) begin
                        n.nxt    = ST_FIN;
                        n.err_to = 1'b1;
                    end else begin
                        n.nxt   = ST_POLL_OP;
                        n.polls = q.polls + POLL_W'(1);
                    end
                end
            end
            ST_WEN: begin
                sh_tx = CMD_WR_EN;
                if (sh_done) begin
                    n.cs_n  = 1'b1;
                    n.state = ST_GAP;
                    n.gap   = '0;
                    n.nxt   = ST_PP_OP;
                end
            end
            ST_PP_OP: begin
                sh_tx = CMD_PROGRAM;
                if (sh_done) begin
                    n.state = ST_PP_ADDR;
                    n.abyte = '0;
                end
            end
            ST_PP_ADDR: begin
                case (q.abyte)
                    2'd0:    sh_tx = addr24[23:16];
                    2'd1:    sh_tx = addr24[15:8];
                    default: sh_tx = addr24[7:0];
                endcase
                if (sh_done) begin
                    if (q.abyte == 2'd2) n.state = ST_PP_DATA;
                    else                 n.abyte = q.abyte + 2'd1;
                end
            end
            ST_PP_DATA: begin
                sh_tx    = wr_data;
                wr_ready = !q.issued && !sh_busy;
                if (wr_valid && wr_ready) begin
                    sh_start = 1'b1;
                    n.issued = 1'b1;
                end
                if (sh_done) begin
                    n.issued     = 1'b0;
                    n.cnt        = q.cnt + LEN_W'(1);
                    n.addr       = q.addr + ADDR_W'(1);
                    n.rem        = q.rem - LEN_W'(1);
                    n.chunk_left = q.chunk_left - LEN_W'(1);
                    if (q.chunk_left == LEN_W'(1)) begin
                        n.cs_n  = 1'b1;
                        n.state = ST_GAP;
                        n.gap   = '0;
                        n.nxt   = (q.rem == LEN_W'(1)) ? ST_FIN : ST_POLL_OP;
                    end
                end
            end
            ST_GAP: begin
                if (q.gap == GAP_W'(GAP_CYC - 1)) begin
                    n.gap   = '0;
                    n.state = q.nxt;
                    n.cs_n  = (q.nxt == ST_FIN);
                    if (q.nxt == ST_PP_OP) n.chunk_left = chunk_len;
                end else begin
                    n.gap = q.gap + GAP_W'(1);
                end
            end
            ST_FIN:  n.state = ST_IDLE;
            default: n.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign req_ready   = (q.state == ST_IDLE);
    assign done        = (q.state == ST_FIN);
    assign err_range   = q.err_rng;
    assign err_timeout = q.err_to;
    assign sent_count  = q.cnt;
    assign spi_cs_n    = q.cs_n;

    // R5
    page_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PP_DATA) |->
            ((q.chunk_left != '0) &&
             ((LEN_W+1)'(q.addr[PAGE_W-1:0]) + (LEN_W+1)'(q.chunk_left) <= (LEN_W+1)'(PAGE))));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= q.len);

    // R10
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_cs_n);

    // R3
    rng_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_range) |-> (sent_count == '0 && spi_cs_n && $past(spi_cs_n)));

    // R8
    to_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> spi_cs_n);

    // R12
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));

endmodule

// File: tb/flash_pgm_engine_bench.sv
module flash_pgm_engine_bench;
    localparam int ADDR_W = 24, LEN_W = 16, PAGE_W = 8, DEV_SIZE = 65536;
    localparam int HALF_CYC = 2, POLL_MAX = 16, GAP_CYC = 2, WD_CYC = 190000;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              req_valid = 1'b0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              wr_valid = 1'b0, wr_ready;
    logic [7:0]        wr_data = '0;
    logic              done, err_range, err_timeout;
    logic [LEN_W-1:0]  sent_count;
    logic              spi_cs_n, spi_sck, spi_mosi;
    logic              spi_miso = 1'b0;

    flash_pgm_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .DEV_SIZE(DEV_SIZE),
        .HALF_CYC(HALF_CYC), .POLL_MAX(POLL_MAX), .GAP_CYC(GAP_CYC)) u_flash_pgm_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .done(done), .err_range(err_range), .err_timeout(err_timeout),
        .sent_count(sent_count), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference state: expected pieces and data
    int         ex_addr[$], ex_len[$];
    logic [7:0] exp_data[$], feed[$];
    int         dev_busy, busy_after, exp_polls, st_frames, frame_total;
    bit         ready_seen, wel, armed, gap_on, active, done_seen, prev_done;
    int         got_cnt, cyc;
    bit         got_rng, got_to;

    // flash device model
    logic [7:0] fb[$];
    logic [7:0] dsh, dstat;
    int         dbits;

    always @(negedge spi_cs_n) if (armed) begin
        fb.delete();
        dbits = 0;
        dstat = {6'b0, wel, (dev_busy > 0)};
        frame_total++;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        dsh = {dsh[6:0], spi_mosi};
        dbits++;
        if (dbits % 8 == 0) fb.push_back(dsh);
    end

    always @(negedge spi_sck) if (!spi_cs_n && dbits >= 8 && dbits < 16)
        spi_miso = dstat[15 - dbits];

    always @(posedge spi_cs_n) if (armed && fb.size() > 0) end_frame();

    task automatic end_frame();
        int bad, a;
        case (fb[0])
            8'h05: begin
                chk(fb.size() == 2, "R7 status frame length", fb.size(), 2);
                st_frames++;
                ready_seen = (dstat[0] == 1'b0);
                if (dev_busy > 0) dev_busy--;
            end
            8'h06: begin
                chk(fb.size() == 1, "R7 write-enable frame length", fb.size(), 1);
                chk(ready_seen, "R7 write enable after idle status", ready_seen, 1);
                chk(st_frames == exp_polls, "R7 status polls per piece", st_frames, exp_polls);
                wel = 1;
            end
            8'h02: begin
                chk(wel, "R7 program preceded by write enable", wel, 1);
                chk(ex_addr.size() > 0, "R5 unexpected program frame", ex_addr.size(), 1);
                if (ex_addr.size() > 0 && fb.size() >= 4) begin
                    a = {fb[1], fb[2], fb[3]};
                    chk(a == ex_addr[0], "R6 R11 piece address", a, ex_addr[0]);
                    chk(fb.size() - 4 == ex_len[0], "R4 R5 piece length", fb.size() - 4, ex_len[0]);
                    bad = 0;
                    for (int i = 4; i < fb.size(); i++) begin
                        if (exp_data.size() == 0) bad++;
                        else if (fb[i] != exp_data.pop_front()) bad++;
                    end
                    chk(bad == 0, "R6 R10 data bytes", bad, 0);
                    void'(ex_addr.pop_front());
                    void'(ex_len.pop_front());
                end
                wel = 0;
                dev_busy = busy_after;
                exp_polls = busy_after + 1;
                st_frames = 0;
                ready_seen = 0;
            end
            default: chk(0, "R6 unknown opcode", fb[0], 2);
        endcase
    endtask

    // write data source
    always @(negedge clk) begin
        cyc++;
        if (feed.size() > 0 && !(gap_on && (cyc % 3 == 0))) begin
            wr_valid = 1'b1;
            wr_data  = feed[0];
        end else begin
            wr_valid = 1'b0;
        end
        #1;
        if (wr_valid && wr_ready && feed.size() > 0) void'(feed.pop_front());
    end

    // per-clock comparison against the reference
    always @(posedge clk) begin
        #2;
        if (rst_n && armed) begin
            chk(!(spi_cs_n && spi_sck), "R11 sck low outside frame", spi_sck, 0);
            chk(!(wr_ready && spi_cs_n), "R10 wr_ready outside frame", wr_ready, 0);
            chk(req_ready == !active, "R12 req_ready vs request in flight", req_ready, !active);
            if (done) begin
                chk(!prev_done, "R12 done lasts one cycle", 1, 0);
                done_seen = 1;
                got_cnt   = sent_count;
                got_rng   = err_range;
                got_to    = err_timeout;
                active    = 0;
            end
            prev_done = done;
        end
    end

    task automatic run_req(input int addr, input int len, input int ib, input int ba,
                           input bit x_rng, input bit x_to, input int x_cnt, input int x_left,
                           input bit gappy, input string tag);
        int a, r, c, room, fr0;
        ex_addr.delete(); ex_len.delete(); exp_data.delete(); feed.delete();
        if (len > 0 && !x_rng) begin
            a = addr; r = len;
            while (r > 0) begin
                room = 256 - (a % 256);
                c = (r < room) ? r : room;
                ex_addr.push_back(a); ex_len.push_back(c);
                a += c; r -= c;
            end
            for (int i = 0; i < len; i++) begin
                exp_data.push_back(8'((i * 37 + addr + len) & 255));
                feed.push_back(8'((i * 37 + addr + len) & 255));
            end
        end
        dev_busy = ib; busy_after = ba; exp_polls = ib + 1;
        st_frames = 0; ready_seen = 0; wel = 0; gap_on = gappy;
        fr0 = frame_total; done_seen = 0;
        @(negedge clk);
        req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        active = 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done_seen) @(negedge clk);
        chk(got_cnt == x_cnt, {tag, " R9 byte count"}, got_cnt, x_cnt);
        chk(got_rng == x_rng, {tag, " R3 range flag"}, got_rng, x_rng);
        chk(got_to == x_to, {tag, " R8 timeout flag"}, got_to, x_to);
        chk(ex_addr.size() == x_left, {tag, " R5 pieces still expected"}, ex_addr.size(), x_left);
        if (x_to) chk(st_frames == POLL_MAX, {tag, " R8 polls before abort"}, st_frames, POLL_MAX);
        if (len == 0 || x_rng) chk(frame_total == fr0, {tag, " no bus frames"}, frame_total - fr0, 0);
        fr0 = frame_total;
        repeat (40) @(negedge clk);
        chk(frame_total == fr0, {tag, " R8 R12 quiet after done"}, frame_total - fr0, 0);
        feed.delete(); exp_data.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 values under reset
        chk(req_ready == 1'b1, "R1 req_ready in reset", req_ready, 1);
        chk(spi_cs_n == 1'b1, "R1 cs high in reset", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 sck low in reset", spi_sck, 0);
        chk(done == 1'b0 && sent_count == '0, "R1 done and count clear", sent_count, 0);
        chk(!err_range && !err_timeout, "R1 flags clear", {err_range, err_timeout}, 0);
        rst_n = 1'b1;
        armed = 1;
        @(negedge clk);
        chk(req_ready && spi_cs_n && !spi_sck, "R1 idle after reset", {req_ready, spi_cs_n, spi_sck}, 3'b110);

        run_req(32'h0100, 0,   0, 0,  0, 0, 0,   0, 0, "R2 empty request");
        run_req(32'hFFF0, 32,  0, 0,  1, 0, 0,   0, 0, "R3 beyond device end");
        run_req(32'hFFF0, 16,  0, 0,  0, 0, 16,  0, 0, "R3 ends at device end");
        run_req(32'h0010, 20,  0, 1,  0, 0, 20,  0, 1, "R4 short write stalled data");
        run_req(32'h00F0, 16,  1, 0,  0, 0, 16,  0, 0, "R4 fills page tail");
        run_req(32'h01F0, 300, 2, 2,  0, 0, 300, 0, 0, "R5 three pieces");
        run_req(32'h0400, 512, 1, 3,  0, 0, 512, 0, 1, "R5 aligned two pages");
        run_req(32'h02FF, 2,   0, 0,  0, 0, 2,   0, 0, "R5 last byte of page");
        run_req(32'h0380, 200, 0, 40, 0, 1, 128, 1, 0, "R8 timeout between pieces");
        run_req(32'h0500, 10,  40, 0, 0, 1, 0,   1, 0, "R8 timeout before first piece");
        run_req(32'h0600, 8,   0, 0,  0, 0, 8,   0, 0, "R7 recovery after timeout");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R12 run did not complete actual=%0d expected=%0d", WD_CYC, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule